// File: doc/BRIEF.md
# Configurable Pipelined Signed Multiplier

This block multiplies two 18-bit two's complement operands into a 36-bit two's complement product. There are three pipeline points: one on operand A, one on operand B and one on the product. Each point is switched in or out by an elaboration parameter. When a point is switched in, it is a register with its own clock enable and its own synchronous clear. When it is switched out, it is a plain wire. The block can therefore run as a purely combinational multiplier, as a one-stage or two-stage pipeline, or as a mix in which one operand is registered and the other is not.

Operand B is taken from one of two places, chosen by a parameter. It comes either from a local input port or from a chain input that a neighbouring multiplier drives. The B value that actually feeds the multiplier is sent out on a chain output, so that a row of these blocks can share one coefficient.

The sampling clock edge can be inverted by a parameter. The active level of each of the six enable and clear inputs can also be inverted, each by its own parameter.

Top module: `pipe_smul`

## Requirements
- R1: `prod` equals the signed product of the A and B operands that reach the multiplier, as a 36-bit two's complement value.
- R2: With `B_SRC` = `B_FROM_PORT`, operand B is taken from `b_in`. With `B_SRC` = `B_FROM_CHAIN`, it is taken from `b_chain_in`.
- R3: `b_chain_out` carries the B operand that reaches the multiplier. With the B register off, it follows the selected source combinationally. With the B register on, it is the register's content.
- R4: A register that is switched in loads its input at the active clock edge when its enable is active and its clear is inactive. Otherwise it holds its value.
- R5: A register whose clear is active at the active clock edge becomes zero, whatever the state of its enable.
- R6: With all three registers off, `prod` follows the operands combinationally.
- R7: With the product register off and both operand registers on, `prod` changes only at clock edges, as the operand registers' enables and clears dictate.
- R8: With the product register off and only one operand register on, `prod` follows the unregistered operand combinationally and the registered operand at clock edges.
- R9: `INV_CLK` = 1 makes every register sample on the falling edge of `clk`. Each `INV_*` control parameter set to 1 makes the matching control active low.
- R10: -131072 times -131072 gives +17179869184 (36'h4_0000_0000) with no overflow. A non-zero product always carries the sign equal to the XOR of the two operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; edge chosen by INV_CLK |
| a_in | input | A_W | Operand A, two's complement |
| b_in | input | B_W | Operand B from the local port |
| b_chain_in | input | B_W | Operand B from a neighbouring block |
| a_en | input | 1 | Load enable of the A register |
| a_clr | input | 1 | Synchronous clear of the A register |
| b_en | input | 1 | Load enable of the B register |
| b_clr | input | 1 | Synchronous clear of the B register |
| p_en | input | 1 | Load enable of the product register |
| p_clr | input | 1 | Synchronous clear of the product register |
| prod | output | A_W+B_W | Signed product |
| b_chain_out | output | B_W | B operand as applied to the multiplier |

## Verification
The register assertions assume that each control input is a clean 0 or 1 at every sampling edge. The bench meets this by changing data and controls only at the inactive edge. The sign and overflow check on the multiplier assumes known operand values, and it stays silent while an operand is unknown. The stimulus sets every input and applies every clear before the first comparison. It then mixes seeded random operands with enables that are mostly on and clears that are rare, followed by directed runs with the enables held off and with both operands at their most negative value.

// File: rtl/pipe_smul_pkg.sv
package pipe_smul_pkg;

    // Where operand B comes from
    typedef enum logic {
        B_FROM_PORT  = 1'b0,
        B_FROM_CHAIN = 1'b1
    } bsrc_e;

    // Control pair of one pipeline register, active high after level fixing
    typedef struct packed {
        logic ce;
        logic rst;
    } stage_ctl_t;

    // Map raw pin levels onto active-high controls
    function automatic stage_ctl_t level_fix(stage_ctl_t raw, bit inv_ce, bit inv_rst);
        stage_ctl_t res;
        res.ce  = raw.ce  ^ inv_ce;
        res.rst = raw.rst ^ inv_rst;
        return res;
    endfunction

endpackage

// File: rtl/pipe_smul_stage.sv
module pipe_smul_stage
    import pipe_smul_pkg::*;
#(
    parameter int W       = 18,
    parameter bit USE     = 1'b1,
    parameter bit INV_CLK = 1'b0
) (
    input  logic             clk,
    input  stage_ctl_t       ctl,
    input  logic [W-1:0]     d,
    output logic [W-1:0]     q
);

    if (USE) begin : g_reg
        logic [W-1:0] r;

        // Edge chosen at elaboration; the clock net itself is never altered
        if (INV_CLK) begin : g_neg
            always_ff @(negedge clk) begin
                if (ctl.rst)     r <= '0;
                else if (ctl.ce) r <= d;
            end
        end else begin : g_pos
            always_ff @(posedge clk) begin
                if (ctl.rst)     r <= '0;
                else if (ctl.ce) r <= d;
            end
        end

        assign q = r;

        // Checker clock aligned with the sampling edge
        logic chk_clk;
        assign chk_clk = clk ^ INV_CLK;

        AST_STAGE_CLEAR: assert property (@(posedge chk_clk)
            ctl.rst |=> (q == '0))
            else $error("stage not cleared");                       // R5
        AST_STAGE_LOAD: assert property (@(posedge chk_clk) disable iff (ctl.rst)
            ctl.ce |=> (q == $past(d)))
            else $error("stage did not load");                      // R4
        AST_STAGE_HOLD: assert property (@(posedge chk_clk) disable iff (ctl.rst)
            !ctl.ce |=> $stable(q))
            else $error("stage changed while disabled");            // R4
    end else begin : g_wire
        assign q = d;
        logic unused_stage;
        assign unused_stage = ^{clk, ctl};
    end

endmodule

// File: rtl/pipe_smul_core.sv
module pipe_smul_core #(
    parameter int A_W = 18,
    parameter int B_W = 18,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    output logic [P_W-1:0] res
);

    assign res = $signed(op_a) * $signed(op_b);

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            if (op_a != '0 && op_b != '0) begin
                AST_NO_OVERFLOW: assert (res[P_W-1] == (op_a[A_W-1] ^ op_b[B_W-1]))
                    else $error("product sign wrong");              // R10
            end else begin
                AST_ZERO_FACTOR: assert (res == '0)
                    else $error("zero factor gave non-zero product"); // R1
            end
        end
    end

endmodule

// File: rtl/pipe_smul.sv
module pipe_smul
    import pipe_smul_pkg::*;
#(
    parameter int    A_W       = 18,
    parameter int    B_W       = 18,
    parameter bit    USE_AREG  = 1'b1,
    parameter bit    USE_BREG  = 1'b1,
    parameter bit    USE_PREG  = 1'b1,
    parameter bsrc_e B_SRC     = B_FROM_PORT,
    parameter bit    INV_CLK   = 1'b0,
    parameter bit    INV_A_EN  = 1'b0,
    parameter bit    INV_A_CLR = 1'b0,
    parameter bit    INV_B_EN  = 1'b0,
    parameter bit    INV_B_CLR = 1'b0,
    parameter bit    INV_P_EN  = 1'b0,
    parameter bit    INV_P_CLR = 1'b0,
    localparam int   P_W       = A_W + B_W
) (
    input  logic           clk,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [B_W-1:0] b_chain_in,
    input  logic           a_en,
    input  logic           a_clr,
    input  logic           b_en,
    input  logic           b_clr,
    input  logic           p_en,
    input  logic           p_clr,
    output logic [P_W-1:0] prod,
    output logic [B_W-1:0] b_chain_out
);

    // Active-high controls per stage
    stage_ctl_t a_ctl, b_ctl, p_ctl;
    assign a_ctl = level_fix(stage_ctl_t'{ce: a_en, rst: a_clr}, INV_A_EN, INV_A_CLR);
    assign b_ctl = level_fix(stage_ctl_t'{ce: b_en, rst: b_clr}, INV_B_EN, INV_B_CLR);
    assign p_ctl = level_fix(stage_ctl_t'{ce: p_en, rst: p_clr}, INV_P_EN, INV_P_CLR);

    // Operand B source, fixed at elaboration
    logic [B_W-1:0] b_pick;
    if (B_SRC == B_FROM_CHAIN) begin : g_chain
        assign b_pick = b_chain_in;
        logic unused_port_b;
        assign unused_port_b = ^b_in;
    end else begin : g_direct
        assign b_pick = b_in;
        logic unused_chain_b;
        assign unused_chain_b = ^b_chain_in;
    end

    logic [A_W-1:0] a_op;
    logic [B_W-1:0] b_op;
    logic [P_W-1:0] prod_raw;

    pipe_smul_stage #(.W(A_W), .USE(USE_AREG), .INV_CLK(INV_CLK)) u_a_stage (
        .clk (clk),
        .ctl (a_ctl),
        .d   (a_in),
        .q   (a_op)
    );

    pipe_smul_stage #(.W(B_W), .USE(USE_BREG), .INV_CLK(INV_CLK)) u_b_stage (
        .clk (clk),
        .ctl (b_ctl),
        .d   (b_pick),
        .q   (b_op)
    );

    assign b_chain_out = b_op;

    pipe_smul_core #(.A_W(A_W), .B_W(B_W)) u_core (
        .op_a (a_op),
        .op_b (b_op),
        .res  (prod_raw)
    );

    pipe_smul_stage #(.W(P_W), .USE(USE_PREG), .INV_CLK(INV_CLK)) u_p_stage (
        .clk (clk),
        .ctl (p_ctl),
        .d   (prod_raw),
        .q   (prod)
    );

    // Both operands registered, no product register: output moves only on edges
    if (USE_AREG && USE_BREG && !USE_PREG) begin : g_chk_opreg
        logic chk_clk;
        assign chk_clk = clk ^ INV_CLK;
        AST_PROD_EDGE_ONLY: assert property (@(posedge chk_clk)
            disable iff (a_ctl.rst || b_ctl.rst)
            (!a_ctl.ce && !b_ctl.ce) |=> $stable(prod))
            else $error("product moved without an operand load");   // R7
    end

    // Registered B: the chain output is cleared one edge after a B clear
    if (USE_BREG) begin : g_chk_chain
        logic chk_clk;
        assign chk_clk = clk ^ INV_CLK;
        AST_CHAIN_CLEAR: assert property (@(posedge chk_clk)
            b_ctl.rst |=> (b_chain_out == '0))
            else $error("chain output not cleared");                // R3
    end

endmodule

// File: tb/test_pipe_smul.sv
`timescale 1ns/1ps
module test_pipe_smul;
    import pipe_smul_pkg::*;

    localparam int AW = 18;
    localparam int BW = 18;
    localparam int PW = AW + BW;
    localparam int NCFG = 16;
    localparam int INV_IDX = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz
    logic clk_n;
    assign clk_n = ~clk;

    logic [AW-1:0] a_i = '0;
    logic [BW-1:0] b_i = '0;
    logic [BW-1:0] c_i = '0;
    logic a_en = 1'b0, a_clr = 1'b1, b_en = 1'b0, b_clr = 1'b1, p_en = 1'b0, p_clr = 1'b1;

    logic [PW-1:0] p_o  [NCFG+1];
    logic [BW-1:0] bc_o [NCFG+1];

    // cfg bit0: A register, bit1: B register, bit2: product register, bit3: chain source
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam bit    UA = (g % 2) == 1;
        localparam bit    UB = ((g / 2) % 2) == 1;
        localparam bit    UP = ((g / 4) % 2) == 1;
        localparam bsrc_e BS = (g >= 8) ? B_FROM_CHAIN : B_FROM_PORT;
        pipe_smul #(.A_W(AW), .B_W(BW), .USE_AREG(UA), .USE_BREG(UB), .USE_PREG(UP),
                    .B_SRC(BS)) i_pipe_smul (
            .clk(clk), .a_in(a_i), .b_in(b_i), .b_chain_in(c_i),
            .a_en(a_en), .a_clr(a_clr), .b_en(b_en), .b_clr(b_clr),
            .p_en(p_en), .p_clr(p_clr),
            .prod(p_o[g]), .b_chain_out(bc_o[g]));
    end

    // Fully inverted copy: inverted clock pin, active-low controls; behaves like cfg 7
    if (1) begin : g_inv
        pipe_smul #(.A_W(AW), .B_W(BW), .USE_AREG(1'b1), .USE_BREG(1'b1), .USE_PREG(1'b1),
                    .B_SRC(B_FROM_PORT), .INV_CLK(1'b1),
                    .INV_A_EN(1'b1), .INV_A_CLR(1'b1), .INV_B_EN(1'b1), .INV_B_CLR(1'b1),
                    .INV_P_EN(1'b1), .INV_P_CLR(1'b1)) i_pipe_smul (
            .clk(clk_n), .a_in(a_i), .b_in(b_i), .b_chain_in(c_i),
            .a_en(~a_en), .a_clr(~a_clr), .b_en(~b_en), .b_clr(~b_clr),
            .p_en(~p_en), .p_clr(~p_clr),
            .prod(p_o[INV_IDX]), .b_chain_out(bc_o[INV_IDX]));
    end

    // Reference model state
    logic signed [AW-1:0] ma [NCFG];
    logic signed [BW-1:0] mb [NCFG];
    logic signed [PW-1:0] mp [NCFG];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic signed [BW-1:0] bsel(int i);
        return (i >= 8) ? $signed(c_i) : $signed(b_i);
    endfunction
    function automatic logic signed [AW-1:0] aeff(int i);
        return ((i & 1) != 0) ? ma[i] : $signed(a_i);
    endfunction
    function automatic logic signed [BW-1:0] beff(int i);
        return ((i & 2) != 0) ? mb[i] : bsel(i);
    endfunction
    function automatic logic signed [PW-1:0] prodc(int i);
        logic signed [PW-1:0] r;
        r = aeff(i) * beff(i);
        return r;
    endfunction
    function automatic logic signed [PW-1:0] pexp(int i);
        return ((i & 4) != 0) ? mp[i] : prodc(i);
    endfunction

    task automatic chk(input bit ok, input string req, input int cfg, input string what,
                       input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cfg%0d %s got %h exp %h", req, cfg, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NCFG; i++) begin
            ma[i] = '0; mb[i] = '0; mp[i] = '0;
        end
    endtask

    // Advance the model by one active edge, using the values before the edge
    task automatic model_edge();
        logic signed [AW-1:0] an [NCFG];
        logic signed [BW-1:0] bn [NCFG];
        logic signed [PW-1:0] pn [NCFG];
        for (int i = 0; i < NCFG; i++) begin
            an[i] = a_clr ? '0 : (a_en ? $signed(a_i) : ma[i]);   // R5 clear wins
            bn[i] = b_clr ? '0 : (b_en ? bsel(i) : mb[i]);
            pn[i] = p_clr ? '0 : (p_en ? prodc(i) : mp[i]);
        end
        for (int i = 0; i < NCFG; i++) begin
            ma[i] = an[i]; mb[i] = bn[i]; mp[i] = pn[i];
        end
    endtask

    task automatic check_all(input string phase);
        for (int i = 0; i < NCFG; i++) begin
            string rq;
            if ((i & 4) != 0)      rq = "R4";
            else if ((i & 3) == 0) rq = "R6";
            else if ((i & 3) == 3) rq = "R7";
            else                   rq = "R8";
            chk(p_o[i] === pexp(i), {rq, "/R1 ", phase}, i, "prod", p_o[i], pexp(i));
            chk(bc_o[i] === beff(i), {"R3/R2 ", phase}, i, "chain_out",
                {{(PW-BW){1'b0}}, bc_o[i]}, {{(PW-BW){1'b0}}, beff(i)});
        end
        chk(p_o[INV_IDX] === pexp(7), {"R9 ", phase}, INV_IDX, "prod", p_o[INV_IDX], pexp(7));
        chk(bc_o[INV_IDX] === beff(7), {"R9 ", phase}, INV_IDX, "chain_out",
            {{(PW-BW){1'b0}}, bc_o[INV_IDX]}, {{(PW-BW){1'b0}}, beff(7)});
    endtask

    // One cycle: drive at the falling edge, check, pass the rising edge, check
    task automatic cycle(input logic [AW-1:0] na, input logic [BW-1:0] nb, input logic [BW-1:0] nc,
                         input logic [5:0] ctl, input string phase);
        @(negedge clk);
        a_i = na; b_i = nb; c_i = nc;
        {a_en, a_clr, b_en, b_clr, p_en, p_clr} = ctl;
        #1 check_all(phase);
        @(posedge clk);
        model_edge();
        #1 check_all(phase);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [AW-1:0] MINV = 18'h20000;

    initial begin
        void'($urandom(32'h0000_5A17));
        // All clears active over a couple of edges
        repeat (2) @(posedge clk);
        model_clear();

        // R5: reset state, clear with enables on still gives zero
        @(negedge clk);
        a_i = 18'h1234; b_i = 18'h0F0F; c_i = 18'h3333;
        {a_en, a_clr, b_en, b_clr, p_en, p_clr} = 6'b111111;
        @(posedge clk);
        model_edge();
        #1;
        for (int i = 0; i < NCFG; i++) begin
            if ((i & 4) != 0) chk(p_o[i] == '0, "R5 clear over enable", i, "prod", p_o[i], '0);
            if ((i & 2) != 0) chk(bc_o[i] == '0, "R5 clear over enable", i, "chain_out",
                                  {{(PW-BW){1'b0}}, bc_o[i]}, '0);
        end
        chk(p_o[INV_IDX] == '0, "R5/R9 clear", INV_IDX, "prod", p_o[INV_IDX], '0);

        // R2: source selection seen combinationally on the unregistered-B configs
        @(negedge clk);
        b_i = 18'h00ABC; c_i = 18'h3F00F;
        #1;
        chk(bc_o[0] == b_i, "R2 port source", 0, "chain_out", {{(PW-BW){1'b0}}, bc_o[0]},
            {{(PW-BW){1'b0}}, b_i});
        chk(bc_o[8] == c_i, "R2 chain source", 8, "chain_out", {{(PW-BW){1'b0}}, bc_o[8]},
            {{(PW-BW){1'b0}}, c_i});
        check_all("R2");
        @(posedge clk);
        model_edge();

        // Random run: enables mostly on, clears rare
        for (int n = 0; n < 400; n++) begin
            logic [5:0] ctl;
            ctl[5] = ($urandom % 4) != 0;
            ctl[4] = ($urandom % 10) == 0;
            ctl[3] = ($urandom % 4) != 0;
            ctl[2] = ($urandom % 10) == 0;
            ctl[1] = ($urandom % 4) != 0;
            ctl[0] = ($urandom % 10) == 0;
            cycle(AW'($urandom), BW'($urandom), BW'($urandom), ctl, "random");
        end

        // R4: enables off, operands move; registers hold
        for (int n = 0; n < 6; n++)
            cycle(AW'($urandom), BW'($urandom), BW'($urandom), 6'b000000, "R4 hold");

        // R10: most negative squared
        for (int n = 0; n < 3; n++)
            cycle(MINV, MINV, MINV, 6'b101010, "R10 corner");
        @(negedge clk);
        #1;
        for (int i = 0; i < NCFG; i++)
            chk(p_o[i] == 36'h4_0000_0000, "R10 min times min", i, "prod", p_o[i], 36'h4_0000_0000);
        chk(p_o[INV_IDX] == 36'h4_0000_0000, "R10/R9 min times min", INV_IDX, "prod",
            p_o[INV_IDX], 36'h4_0000_0000);

        // Mixed signs and extremes, directed
        cycle(18'h1FFFF, MINV, 18'h1FFFF, 6'b101010, "R1 extremes");
        cycle(18'h3FFFF, 18'h3FFFF, MINV, 6'b101010, "R1 minus one");
        cycle(18'h00000, 18'h1FFFF, 18'h00001, 6'b101010, "R1 zero");
        repeat (3) cycle(18'h00007, 18'h3FFF9, 18'h00005, 6'b101010, "R1 flush");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule